// File: doc/BRIEF.md
# Dual-Channel PWM Generator with AND-Combined Output

This block holds two independent pulse-width modulation channels, A and B. Each channel runs a down-counter that starts from its interval value, counts to zero and reloads, so one period lasts interval + 1 clock cycles. The output of a channel is high from the reload until the count falls to the match value, then low until the next reload. The match value together with the interval therefore sets the duty cycle.

Each channel can invert its signal and can raise a one-cycle event pulse when its output pin rises, falls, or does either. An optional combine mode drives pin A with the AND of both channels' signals after each channel's own inversion, while pin B keeps channel B's signal. The interval, match, invert and edge-select inputs are static configuration. They are meant to be changed while the channels are disabled.

Top module: `dual_pwm_and`

## Requirements
- R1: While reset is held, and on the first cycle after it, both pins and both event outputs are 0.
- R2: With match < interval and no inversion, an enabled channel repeats with a period of interval + 1 cycles and is high for interval − match cycles of each period.
- R3: With match ≥ interval the uninverted channel stays low. With match = 0 it is low for exactly one cycle per period.
- R4: With invert = 1 the channel's signal is the complement of its uninverted signal, so it is high for match + 1 cycles of each period.
- R5: A disabled channel holds its counter at the interval value, and its pin equals its invert input. Enabling it makes the uninverted pin go high on the next clock edge.
- R6: The edge select is encoded as 00 no events, 01 rising edges, 10 falling edges, 11 both. An event is a one-cycle pulse in the same cycle that the pin shows the new level.
- R7: With combine = 1, pin A is the AND of channel A's and channel B's signals, and pin B is still channel B's signal.
- R8: With combine = 0, each pin carries only its own channel's signal.
- R9: Inversion is applied to each channel before the AND of the combine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_a | input | 1 | Channel A run enable |
| en_b | input | 1 | Channel B run enable |
| interval_a | input | W | Channel A reload value |
| interval_b | input | W | Channel B reload value |
| match_a | input | W | Channel A compare value |
| match_b | input | W | Channel B compare value |
| inv_a | input | 1 | Channel A output inversion |
| inv_b | input | 1 | Channel B output inversion |
| edge_sel_a | input | 2 | Channel A event edge select |
| edge_sel_b | input | 2 | Channel B event edge select |
| combine | input | 1 | Drive pin A with A AND B |
| pwm_a | output | 1 | Pin A |
| pwm_b | output | 1 | Pin B |
| evt_a | output | 1 | Pin A edge event pulse |
| evt_b | output | 1 | Pin B edge event pulse |

## Verification
The combine checks are the hardest to set up. They need both counters in a known phase relation, and the ports give no direct way to align counters. The stimulus disables both channels, which parks each counter at its interval, and then enables both on the same edge so the reloads line up. After a settling time, a 100-cycle window is a whole number of periods for every chosen interval. The number of high cycles and event pulses in that window is then fixed regardless of phase, and it differs between the inverted and uninverted combine cases.

// File: rtl/dual_pwm_and.sv
module dual_pwm_and #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_a,
  input  logic         en_b,
  input  logic [W-1:0] interval_a,
  input  logic [W-1:0] interval_b,
  input  logic [W-1:0] match_a,
  input  logic [W-1:0] match_b,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic [1:0]   edge_sel_a,
  input  logic [1:0]   edge_sel_b,
  input  logic         combine,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         evt_a,
  output logic         evt_b
);
  localparam int NCH = 2;

  logic [NCH-1:0] en_v, inv_v, sig;
  logic [W-1:0]   ival [NCH];
  logic [W-1:0]   mval [NCH];
  logic           nxt_a, nxt_b;

  assign en_v    = {en_b, en_a};
  assign inv_v   = {inv_b, inv_a};
  assign ival[0] = interval_a;
  assign ival[1] = interval_b;
  assign mval[0] = match_a;
  assign mval[1] = match_b;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                      cnt <= '0;
      else if (!en_v[i] || cnt == '0) cnt <= ival[i];
      else                             cnt <= cnt - 1'b1;
    end
    assign sig[i] = (en_v[i] && (cnt > mval[i])) ^ inv_v[i];
  end

  assign nxt_a = combine ? (sig[0] & sig[1]) : sig[0];
  assign nxt_b = sig[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
      evt_a <= 1'b0;
      evt_b <= 1'b0;
    end else begin
      pwm_a <= nxt_a;
      pwm_b <= nxt_b;
      evt_a <= (edge_sel_a[0] & ~pwm_a & nxt_a) | (edge_sel_a[1] & pwm_a & ~nxt_a);
      evt_b <= (edge_sel_b[0] & ~pwm_b & nxt_b) | (edge_sel_b[1] & pwm_b & ~nxt_b);
    end
  end

  a_r5_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |=> pwm_b == $past(inv_b));

  a_r6_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    evt_a |-> pwm_a != $past(pwm_a));

  a_r6_rise_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_b && pwm_b) |-> $past(edge_sel_b[0]));

  a_r7_and_implies_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(combine) && pwm_a) |-> pwm_b);

endmodule

// File: tb/dual_pwm_and_tb.sv
`timescale 1ns/1ps
module dual_pwm_and_tb;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic en_a = 0, en_b = 0, inv_a = 0, inv_b = 0, combine = 0;
  logic [W-1:0] interval_a = 0, interval_b = 0, match_a = 0, match_b = 0;
  logic [1:0] edge_sel_a = 0, edge_sel_b = 0;
  logic pwm_a, pwm_b, evt_a, evt_b;
  int total = 0, bad = 0;
  int hi_a, hi_b, ev_a, ev_b;

  always #10 clk = ~clk;

  dual_pwm_and #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
    .interval_a(interval_a), .interval_b(interval_b),
    .match_a(match_a), .match_b(match_b), .inv_a(inv_a), .inv_b(inv_b),
    .edge_sel_a(edge_sel_a), .edge_sel_b(edge_sel_b), .combine(combine),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .evt_a(evt_a), .evt_b(evt_b));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(int ia, int ma, int ib, int mb, bit ina, bit inb,
                       bit [1:0] sa, bit [1:0] sb, bit cmb, bit run);
    @(negedge clk);
    en_a = 0; en_b = 0;
    interval_a = W'(ia); match_a = W'(ma); interval_b = W'(ib); match_b = W'(mb);
    inv_a = ina; inv_b = inb; edge_sel_a = sa; edge_sel_b = sb; combine = cmb;
    repeat (2) @(negedge clk);
    en_a = run; en_b = run;
    repeat (25) @(negedge clk);
  endtask

  task automatic measure();
    hi_a = 0; hi_b = 0; ev_a = 0; ev_b = 0;
    for (int k = 0; k < 100; k++) begin
      hi_a += int'(pwm_a); hi_b += int'(pwm_b);
      ev_a += int'(evt_a); ev_b += int'(evt_b);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pwm_a", int'(pwm_a), 0);
    check("R1 pwm_b", int'(pwm_b), 0);
    check("R1 evt", int'(evt_a | evt_b), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", int'(pwm_a | pwm_b | evt_a | evt_b), 0);
  endtask

  task automatic t_duty();
    setup(9, 4, 9, 3, 0, 0, 2'b01, 2'b01, 0, 1);
    measure();
    check("R2 high A", hi_a, 50);
    check("R2 high B", hi_b, 60);
    check("R6 rise A", ev_a, 10);
    check("R6 rise B", ev_b, 10);
  endtask

  task automatic t_first();
    setup(9, 4, 9, 3, 0, 0, 2'b00, 2'b00, 0, 0);
    check("R5 parked low", int'(pwm_a), 0);
    en_a = 1;
    @(negedge clk);
    check("R5 first edge high", int'(pwm_a), 1);
  endtask

  task automatic t_extreme();
    setup(9, 9, 9, 0, 0, 0, 2'b11, 2'b10, 0, 1);
    measure();
    check("R3 match=interval", hi_a, 0);
    check("R3 match=0", hi_b, 90);
    check("R6 none on flat", ev_a, 0);
    check("R6 fall B", ev_b, 10);
  endtask

  task automatic t_invert();
    setup(9, 2, 4, 2, 1, 1, 2'b11, 2'b11, 0, 1);
    measure();
    check("R4 inv A", hi_a, 30);
    check("R4 inv B", hi_b, 60);
    check("R6 both A", ev_a, 20);
    check("R6 both B", ev_b, 40);
  endtask

  task automatic t_disable();
    setup(9, 4, 9, 3, 1, 0, 2'b11, 2'b11, 0, 0);
    measure();
    check("R5 off inv A", hi_a, 100);
    check("R5 off B", hi_b, 0);
    check("R5 no events", ev_a + ev_b, 0);
  endtask

  task automatic t_combine();
    setup(9, 4, 4, 2, 0, 0, 2'b01, 2'b00, 1, 1);
    measure();
    check("R7 A and B", hi_a, 20);
    check("R7 B unchanged", hi_b, 40);
    check("R7 rise A", ev_a, 10);
    check("R6 none B", ev_b, 0);
  endtask

  task automatic t_comb_inv();
    setup(9, 4, 9, 3, 1, 0, 2'b00, 2'b00, 1, 1);
    measure();
    check("R9 inv then AND", hi_a, 10);
    check("R9 B", hi_b, 60);
  endtask

  task automatic t_nocomb();
    setup(9, 4, 9, 3, 1, 0, 2'b00, 2'b00, 0, 1);
    measure();
    check("R8 A own", hi_a, 50);
    check("R8 B own", hi_b, 60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_duty();
    t_first();
    t_extreme();
    t_invert();
    t_disable();
    t_combine();
    t_comb_inv();
    t_nocomb();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule